// File: doc/BRIEF.md
# Context-Switch Microcode Sequencer

This block runs a small stored program that decides, for a graphics-style engine, whether the current register context must be written out (save) or brought back in (load), and then steers the register-block moves that do it. The program is a list of 24-bit words held in an on-block program store of 256 entries. A host fills the store and pulses a start input. The sequencer then executes one word per cycle from address 0 until it meets the end word, and raises a done level.

Decisions are taken on a file of 128 single-bit flags, addressed as bank*32+bit. Some flags are set from outside: four request inputs latch their flags, and the engine-busy input is visible as a flag. Other flags are written by the program. One flag always reads as one, so the program can branch unconditionally.

A transfer word hands the start offset, the register count and the current direction flag to an external data mover, and the program stops until that mover pulses done. Words that the sequencer does not execute itself leave as a one-cycle command strobe for neighbouring logic to act on.

Top module: `ctxseq_top`

## Requirements
- R1: After reset the sequencer is idle. `running`, `done`, `xfer_req` and `cmd_strobe` are 0, and `len_value` is 0.
- R2: A host write stores `host_wdata` at `host_addr` only while `running` is 0. A write made while running leaves the stored word unchanged.
- R3: A `host_start` pulse while idle sets the program counter to 0, raises `running` and clears `done`. A pulse while running has no effect.
- R4: Opcode bits 23:20 = 4 is a branch. Bits 15:8 give the target and bits 6:0 the flag. When bit 7 is 0 the branch is taken if the flag is 1; when bit 7 is 1 it is taken if the flag is 0. A branch that is not taken advances to the next word.
- R5: Opcode 5 is a wait. The program counter holds until the flag in bits 6:0 equals bit 7.
- R6: Opcode 7 writes bit 7 into the flag in bits 6:0. Flag 104 always reads 1 and flag 96 always reads `engine_busy`. Writes to these two flags are ignored.
- R7: Opcode 2 loads bits 19:0 into the length register shown on `len_value`, starting the next cycle.
- R8: Opcode 1 is a transfer. It raises `xfer_req` with `xfer_offset` = bits 13:0, `xfer_count` = bits 19:14 and `xfer_save` = flag 0. The request and its fields hold until a cycle with `xfer_done`, after which the request drops and the program counter advances by one.
- R9: Any other word, except the end word, produces a one-cycle `cmd_strobe` with the word on `cmd_word` and then advances. This includes 0x600007, 0x600009 and 0x60000A.
- R10: Word 0x60000E stops execution. `running` falls and `done` rises on the same edge, and `done` stays high until the next accepted start.
- R11: A high level on `user_save_req`, `user_load_req`, `auto_save_req` or `auto_load_req` sets flag 5, 6, 100 or 101 respectively. This set wins over a program write to the same flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Program store write enable |
| host_addr | input | 8 | Program store write address |
| host_wdata | input | 24 | Program word to write |
| host_start | input | 1 | Start pulse |
| user_save_req | input | 1 | Sets flag 5 |
| user_load_req | input | 1 | Sets flag 6 |
| auto_save_req | input | 1 | Sets flag 100 |
| auto_load_req | input | 1 | Sets flag 101 |
| engine_busy | input | 1 | Read as flag 96 |
| xfer_req | output | 1 | Register-block transfer request |
| xfer_offset | output | 14 | First register word offset |
| xfer_count | output | 6 | Number of registers |
| xfer_save | output | 1 | Direction: 1 save, 0 load |
| xfer_done | input | 1 | Transfer complete pulse |
| cmd_strobe | output | 1 | One-cycle command strobe |
| cmd_word | output | 24 | Word carried by the strobe |
| len_value | output | 20 | Length register |
| running | output | 1 | Program executing |
| done | output | 1 | End word reached |

## Verification
The assertions assume that `xfer_done` is driven only as a single-cycle reply to an outstanding `xfer_req`. They also assume that the host loads a complete program, with every reachable address written, before the first start. The stimulus keeps to this: it fills the whole store with end words first, then overlays each program. Its transfer responder waits a few cycles after seeing a request and then answers with one done pulse. Starts and writes that arrive during a run are sent on purpose, to show that they are dropped.

// File: rtl/ctxseq_pkg.sv
package ctxseq_pkg;

    localparam int WORD_W = 24;
    localparam int LEN_W  = 20;
    localparam int OFS_W  = 14;
    localparam int CNT_W  = 6;
    localparam int FIDX_W = 7;
    localparam int TGT_W  = 8;

    localparam logic [3:0] OP_XFER = 4'h1;
    localparam logic [3:0] OP_LEN  = 4'h2;
    localparam logic [3:0] OP_BRA  = 4'h4;
    localparam logic [3:0] OP_WAIT = 4'h5;
    localparam logic [3:0] OP_SET  = 4'h7;

    localparam logic [WORD_W-1:0] END_WORD = 24'h60000E;

    localparam int FLG_DIR   = 0;
    localparam int FLG_USAVE = 5;
    localparam int FLG_ULOAD = 6;
    localparam int FLG_BUSY  = 96;
    localparam int FLG_ASAVE = 100;
    localparam int FLG_ALOAD = 101;
    localparam int FLG_ONE   = 104;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_XFER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              is_xfer;
        logic              is_len;
        logic              is_bra;
        logic              is_wait;
        logic              is_set;
        logic              is_end;
        logic              pol;
        logic [FIDX_W-1:0] fidx;
        logic [TGT_W-1:0]  target;
        logic [CNT_W-1:0]  count;
        logic [OFS_W-1:0]  offset;
        logic [LEN_W-1:0]  imm;
    } insn_t;

endpackage

// File: rtl/ctxseq_decode.sv
module ctxseq_decode
    import ctxseq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output insn_t             info
);

    logic [3:0] op;

    always_comb begin
        op           = word[23:20];
        info.is_xfer = (op == OP_XFER);
        info.is_len  = (op == OP_LEN);
        info.is_bra  = (op == OP_BRA);
        info.is_wait = (op == OP_WAIT);
        info.is_set  = (op == OP_SET);
        info.is_end  = (word == END_WORD);
        info.pol     = word[7];
        info.fidx    = word[6:0];
        info.target  = word[15:8];
        info.count   = word[19:14];
        info.offset  = word[13:0];
        info.imm     = word[19:0];
    end

endmodule

// File: rtl/ctxseq_progmem.sv
module ctxseq_progmem #(
    parameter int DEPTH  = 256,
    parameter int WORD_W = 24,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/ctxseq_flags.sv
module ctxseq_flags
    import ctxseq_pkg::*;
#(
    parameter int NFLAG = 128,
    localparam int IDX_W = $clog2(NFLAG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val,
    input  logic [3:0]       req_in,
    input  logic             busy_in,
    output logic             dir_flag
);

    localparam int NREQ = 4;
    localparam int REQ_IDX [NREQ] = '{FLG_USAVE, FLG_ULOAD, FLG_ASAVE, FLG_ALOAD};

    logic [NFLAG-1:0] file_d, file_q;
    logic             writable;

    always_comb begin
        file_d   = file_q;
        writable = (wr_idx != IDX_W'(FLG_BUSY)) && (wr_idx != IDX_W'(FLG_ONE));
        if (wr_en && writable) begin
            file_d[wr_idx] = wr_val;
        end
        for (int k = 0; k < NREQ; k++) begin
            if (req_in[k]) begin
                file_d[REQ_IDX[k]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            file_q <= '0;
        end else begin
            file_q <= file_d;
        end
    end

    always_comb begin
        if (rd_idx == IDX_W'(FLG_BUSY)) begin
            rd_val = busy_in;
        end else if (rd_idx == IDX_W'(FLG_ONE)) begin
            rd_val = 1'b1;
        end else begin
            rd_val = file_q[rd_idx];
        end
    end

    assign dir_flag = file_q[FLG_DIR];

endmodule

// File: rtl/ctxseq_top.sv
module ctxseq_top
    import ctxseq_pkg::*;
#(
    parameter int PROG_DEPTH = 256,
    parameter int NFLAG      = 128,
    localparam int ADDR_W    = $clog2(PROG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [23:0]       host_wdata,
    input  logic              host_start,
    input  logic              user_save_req,
    input  logic              user_load_req,
    input  logic              auto_save_req,
    input  logic              auto_load_req,
    input  logic              engine_busy,
    output logic              xfer_req,
    output logic [13:0]       xfer_offset,
    output logic [5:0]        xfer_count,
    output logic              xfer_save,
    input  logic              xfer_done,
    output logic              cmd_strobe,
    output logic [23:0]       cmd_word,
    output logic [19:0]       len_value,
    output logic              running,
    output logic              done
);

    localparam int IDX_W = $clog2(NFLAG);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] pc;
        logic [LEN_W-1:0]  len;
        logic [OFS_W-1:0]  xoff;
        logic [CNT_W-1:0]  xcnt;
        logic              xdir;
        logic              cmd_stb;
        logic [WORD_W-1:0] cmd_w;
        logic              done;
    } seq_t;

    seq_t              s_d, s_q;
    logic [WORD_W-1:0] insn_word;
    insn_t             dec;
    logic              fl_val, fl_we, dir_flag, taken;
    logic [ADDR_W-1:0] pc_inc;

    ctxseq_progmem #(
        .DEPTH  (PROG_DEPTH),
        .WORD_W (WORD_W)
    ) i_mem (
        .clk   (clk),
        .we    (host_we && (s_q.state == ST_IDLE)),
        .waddr (host_addr),
        .wdata (host_wdata),
        .raddr (s_q.pc),
        .rdata (insn_word)
    );

    ctxseq_decode i_dec (
        .word (insn_word),
        .info (dec)
    );

    ctxseq_flags #(
        .NFLAG (NFLAG)
    ) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (IDX_W'(dec.fidx)),
        .rd_val   (fl_val),
        .wr_en    (fl_we),
        .wr_idx   (IDX_W'(dec.fidx)),
        .wr_val   (dec.pol),
        .req_in   ({auto_load_req, auto_save_req, user_load_req, user_save_req}),
        .busy_in  (engine_busy),
        .dir_flag (dir_flag)
    );

    always_comb begin
        s_d         = s_q;
        s_d.cmd_stb = 1'b0;
        fl_we       = 1'b0;
        pc_inc      = s_q.pc + 1'b1;
        taken       = dec.pol ? ~fl_val : fl_val;
        unique case (s_q.state)
            ST_IDLE: begin
                if (host_start) begin
                    s_d.pc    = '0;
                    s_d.state = ST_RUN;
                    s_d.done  = 1'b0;
                end
            end
            ST_RUN: begin
                if (dec.is_xfer) begin
                    s_d.xoff  = dec.offset;
                    s_d.xcnt  = dec.count;
                    s_d.xdir  = dir_flag;
                    s_d.state = ST_XFER;
                end else if (dec.is_len) begin
                    s_d.len = dec.imm;
                    s_d.pc  = pc_inc;
                end else if (dec.is_bra) begin
                    s_d.pc = taken ? ADDR_W'(dec.target) : pc_inc;
                end else if (dec.is_wait) begin
                    if (fl_val == dec.pol) begin
                        s_d.pc = pc_inc;
                    end
                end else if (dec.is_set) begin
                    fl_we  = 1'b1;
                    s_d.pc = pc_inc;
                end else if (dec.is_end) begin
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.cmd_stb = 1'b1;
                    s_d.cmd_w   = insn_word;
                    s_d.pc      = pc_inc;
                end
            end
            ST_XFER: begin
                if (xfer_done) begin
                    s_d.state = ST_RUN;
                    s_d.pc    = pc_inc;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign xfer_req    = (s_q.state == ST_XFER);
    assign xfer_offset = s_q.xoff;
    assign xfer_count  = s_q.xcnt;
    assign xfer_save   = s_q.xdir;
    assign cmd_strobe  = s_q.cmd_stb;
    assign cmd_word    = s_q.cmd_w;
    assign len_value   = s_q.len;
    assign running     = (s_q.state != ST_IDLE);
    assign done        = s_q.done;

endmodule

// File: rtl/ctxseq_chk.sv
module ctxseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_start,
    input logic        xfer_req,
    input logic [13:0] xfer_offset,
    input logic [5:0]  xfer_count,
    input logic        xfer_save,
    input logic        xfer_done,
    input logic        cmd_strobe,
    input logic [19:0] len_value,
    input logic        running,
    input logic        done
);

    p_start_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_start && !running) |=> (running && !done));

    p_req_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_offset)
                                      && $stable(xfer_count) && $stable(xfer_save)));

    p_req_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_done) |=> !xfer_req);

    p_req_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> running);

    p_cmd_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> running);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);

    p_len_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(len_value));

endmodule

bind ctxseq_top ctxseq_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_start  (host_start),
    .xfer_req    (xfer_req),
    .xfer_offset (xfer_offset),
    .xfer_count  (xfer_count),
    .xfer_save   (xfer_save),
    .xfer_done   (xfer_done),
    .cmd_strobe  (cmd_strobe),
    .len_value   (len_value),
    .running     (running),
    .done        (done)
);

// File: tb/test_ctxseq_top.sv
module test_ctxseq_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [23:0] host_wdata = '0;
    logic        host_start = 1'b0;
    logic        user_save_req = 1'b0, user_load_req = 1'b0;
    logic        auto_save_req = 1'b0, auto_load_req = 1'b0;
    logic        engine_busy = 1'b0;
    logic        xfer_req, xfer_save, xfer_done = 1'b0;
    logic [13:0] xfer_offset;
    logic [5:0]  xfer_count;
    logic        cmd_strobe, running, done;
    logic [23:0] cmd_word;
    logic [19:0] len_value;

    int n_chk = 0, n_fail = 0, cycles = 0, wait_cnt = 0;

    int        mmem [256];
    bit [127:0] mflag;
    int        mpc, mst, mlen, mxoff, mxcnt, mcmdw;
    bit        mxdir, mcmd, mdone;

    int  cmd_log [$];
    int  xlog [$];
    bit  prev_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctxseq_top i_ctxseq_top (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_start(host_start),
        .user_save_req(user_save_req), .user_load_req(user_load_req),
        .auto_save_req(auto_save_req), .auto_load_req(auto_load_req),
        .engine_busy(engine_busy), .xfer_req(xfer_req), .xfer_offset(xfer_offset),
        .xfer_count(xfer_count), .xfer_save(xfer_save), .xfer_done(xfer_done),
        .cmd_strobe(cmd_strobe), .cmd_word(cmd_word), .len_value(len_value),
        .running(running), .done(done)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int mflag_rd(int f);
        if (f == 96) return int'(engine_busy);
        if (f == 104) return 1;
        return int'(mflag[f]);
    endfunction

    task automatic model_reset();
        mflag = '0; mpc = 0; mst = 0; mlen = 0; mxoff = 0; mxcnt = 0;
        mxdir = 0; mcmd = 0; mcmdw = 0; mdone = 0;
    endtask

    task automatic model_step();
        int ins, op, f, pol, fv, old_st;
        bit wr;
        old_st = mst;
        ins = mmem[mpc];
        op  = (ins >> 20) & 15;
        f   = ins & 127;
        pol = (ins >> 7) & 1;
        fv  = mflag_rd(f);
        wr  = 0;
        mcmd = 0;
        if (old_st == 0) begin
            if (host_start) begin mpc = 0; mst = 1; mdone = 0; end
        end else if (old_st == 1) begin
            if (op == 1) begin
                mxoff = ins & 'h3fff; mxcnt = (ins >> 14) & 63; mxdir = mflag[0]; mst = 2;
            end else if (op == 2) begin
                mlen = ins & 'hfffff; mpc = (mpc + 1) % 256;
            end else if (op == 4) begin
                if ((pol == 1) ? (fv == 0) : (fv == 1)) mpc = (ins >> 8) & 255;
                else mpc = (mpc + 1) % 256;
            end else if (op == 5) begin
                if (fv == pol) mpc = (mpc + 1) % 256;
            end else if (op == 7) begin
                wr = 1; mpc = (mpc + 1) % 256;
            end else if (ins == 'h60000E) begin
                mst = 0; mdone = 1;
            end else begin
                mcmd = 1; mcmdw = ins; mpc = (mpc + 1) % 256;
            end
        end else begin
            if (xfer_done) begin mst = 1; mpc = (mpc + 1) % 256; end
        end
        if (wr && f != 96 && f != 104) mflag[f] = pol[0];
        if (user_save_req) mflag[5] = 1;
        if (user_load_req) mflag[6] = 1;
        if (auto_save_req) mflag[100] = 1;
        if (auto_load_req) mflag[101] = 1;
        if (host_we && old_st == 0) mmem[host_addr] = int'(host_wdata);
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst_n) model_reset(); else model_step();
        #1;
        cycles++;
        if (rst_n) begin
            chk("R10 running", running, mst != 0);
            chk("R10 done", done, mdone);
            chk("R8 xfer_req", xfer_req, mst == 2);
            chk("R8 xfer_offset", xfer_offset, mxoff);
            chk("R8 xfer_count", xfer_count, mxcnt);
            chk("R8 xfer_save", xfer_save, mxdir);
            chk("R9 cmd_strobe", cmd_strobe, mcmd);
            if (mcmd) chk("R9 cmd_word", cmd_word, mcmdw);
            chk("R7 len_value", len_value, mlen);
        end
        if (cmd_strobe) cmd_log.push_back(int'(cmd_word));
        if (xfer_req && !prev_req)
            xlog.push_back((int'(xfer_save) << 20) | (int'(xfer_count) << 14) | int'(xfer_offset));
        prev_req = xfer_req;
        if (xfer_req && !xfer_done) begin
            wait_cnt++;
            if (wait_cnt >= 3) begin xfer_done = 1'b1; wait_cnt = 0; end
        end else begin
            xfer_done = 1'b0;
        end
        if (cycles > MAX_CYCLES) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, MAX_CYCLES);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wr_word(int a, int d);
        host_we = 1'b1; host_addr = 8'(a); host_wdata = 24'(d);
        tick();
        host_we = 1'b0;
    endtask

    task automatic start_run();
        cmd_log.delete(); xlog.delete();
        host_start = 1'b1; tick(); host_start = 1'b0;
    endtask

    task automatic wait_end(string tag);
        int n = 0;
        while (!(done && !running) && n < 2000) begin tick(); n++; end
        chk({tag, " run ends with done"}, done && !running, 1);
    endtask

    task automatic chk_cmds(string tag, int exp [$]);
        chk({tag, " command count"}, cmd_log.size(), exp.size());
        foreach (exp[i]) begin
            if (i < cmd_log.size()) chk({tag, " command word"}, cmd_log[i], exp[i]);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 running", running, 0);
        chk("R1 done", done, 0);
        chk("R1 xfer_req", xfer_req, 0);
        chk("R1 cmd_strobe", cmd_strobe, 0);
        chk("R1 len_value", len_value, 0);

        for (int a = 0; a < 256; a++) wr_word(a, 'h60000E);
        // Program A: context switch flow
        wr_word(0, 'h400A64); wr_word(1, 'h400A05); wr_word(2, 'h401465);
        wr_word(3, 'h401406); wr_word(4, 'h401E68);
        wr_word(10, 'h700080); wr_word(11, 'h10C040); wr_word(12, 'h600009);
        wr_word(13, 'h401E68);
        wr_word(20, 'h700000); wr_word(21, 'h500060); wr_word(22, 'h212345);
        wr_word(23, 'h104100); wr_word(24, 'h600007); wr_word(25, 'h401E68);
        wr_word(30, 'h700005); wr_word(31, 'h700006); wr_word(32, 'h60000E);

        // Run 1: nothing pending, straight exit (R4, R10)
        start_run();
        wait_end("R10");
        chk_cmds("R4 idle exit", '{});
        chk("R8 no transfer when idle", xlog.size(), 0);

        // Run 2: user save pending (R11, R4, R8, R9)
        user_save_req = 1'b1; tick(); user_save_req = 1'b0;
        start_run();
        wait_end("R11");
        chk_cmds("R9 save path", '{'h600009});
        chk("R8 save transfer count", xlog.size(), 1);
        if (xlog.size() > 0) chk("R8 save transfer fields", xlog[0], (1 << 20) | (3 << 14) | 'h40);
        chk("R7 len untouched on save path", len_value, 0);

        // Run 3: auto load pending, engine busy holds the wait (R5, R11, R7)
        engine_busy = 1'b1;
        auto_load_req = 1'b1; tick(); auto_load_req = 1'b0;
        start_run();
        repeat (8) tick();
        chk("R5 stalled while busy", running, 1);
        chk("R5 no transfer yet", xlog.size(), 0);
        chk("R5 no command yet", cmd_log.size(), 0);
        engine_busy = 1'b0;
        wait_end("R5");
        chk_cmds("R11 load path", '{'h600007});
        chk("R8 load transfer count", xlog.size(), 1);
        if (xlog.size() > 0) chk("R8 load transfer fields", xlog[0], (1 << 14) | 'h100);
        chk("R7 length loaded", len_value, 'h12345);

        // Program B: polarity and protected flags
        wr_word(0, 'h700068); wr_word(1, 'h4005E8); wr_word(2, 'h900001);
        wr_word(3, 'h7000E0); wr_word(4, 'h400860); wr_word(5, 'h900002);
        wr_word(6, 'h700087); wr_word(7, 'h500087); wr_word(8, 'h400C87);
        wr_word(9, 'h900003); wr_word(10, 'h60000E);

        // Run 4: a write and a second start arrive while running (R2, R3, R6)
        start_run();
        host_we = 1'b1; host_addr = 8'd9; host_wdata = 24'h900009; host_start = 1'b1;
        tick();
        host_we = 1'b0; host_start = 1'b0;
        wait_end("R3");
        chk_cmds("R6 R3 protected flags and ignored restart", '{'h900001, 'h900002, 'h900003});

        // Run 5: the word written during run 4 must not have landed (R2)
        start_run();
        wait_end("R2");
        chk_cmds("R2 write during run ignored", '{'h900001, 'h900002, 'h900003});

        repeat (3) tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule